// File: doc/BRIEF.md
# Execute-Stage Branch Redirect Unit

This block sits in the execute stage of a simple in-order 64-bit processor. It turns a resolved taken branch, or an interrupt-return instruction, into a redirect for the fetch stage. The redirect carries a target address and, for an interrupt return, a new machine-state word. The redirect is captured in a register, so fetch and decode see it one clock after execute resolves it. This keeps the long combinational path from branch resolution out of the fetch and decode logic.

An interrupt return takes the same path as a branch. Its target comes from operand B, which holds the saved return address. Its new machine state comes from operand A, which holds the saved state. The block also keeps a come-from register. This register holds the instruction address of the most recent taken branch or interrupt return, and software reads it as a special-purpose register. While a redirect is pending, the instruction sitting in execute is on the wrong path, so the block discards it.

Top module: `branch_redirect_unit`

## Requirements
- R1: After a synchronous active-low reset, `redir_valid` and `flush` are 0 and `cf_rd_data` reads zero.
- R2: An accepted instruction is one with `ex_valid`=1 and `stall`=0 in a cycle where `redir_valid`=0. For an accepted taken branch (`br_is_branch`=1, `br_taken`=1, `ex_is_rfi`=0), in the next cycle `redir_valid`=1, `redir_addr` equals `br_target`, and `redir_set_msr`=0.
- R3: An accepted taken branch loads the come-from register with `ex_nia`. The new value is readable on `cf_rd_data` from the next cycle.
- R4: An accepted branch with `br_taken`=0 raises no redirect and leaves the come-from register unchanged.
- R5: An accepted interrupt return (`ex_is_rfi`=1) does three things in the next cycle. It raises `redir_valid`=1 with `redir_addr` equal to `opnd_b`, `redir_msr` equal to `opnd_a`, and `redir_set_msr`=1. It loads the come-from register with `ex_nia`. The branch inputs are ignored in that cycle.
- R6: Both the redirect target and the come-from value pass all 64 bits unchanged, including address bits 1:0. Those two bits are not cleared.
- R7: In a cycle where `redir_valid`=1, the instruction in execute is squashed. It causes no redirect in the next cycle and does not change the come-from register.
- R8: An instruction presented with `stall`=1 has no effect: no redirect follows and the come-from register is unchanged.
- R9: With `ex_valid`=0, the other inputs have no effect on the redirect or on the come-from register.
- R10: `flush` equals `redir_valid` in every cycle. The redirect lasts exactly one cycle per resolved instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | Instruction present in execute |
| stall | input | 1 | Execute stalled; instruction not accepted |
| ex_nia | input | 64 | Address of the instruction in execute |
| br_is_branch | input | 1 | Instruction is a branch |
| br_taken | input | 1 | Branch condition resolved as taken |
| br_target | input | 64 | Branch target address |
| ex_is_rfi | input | 1 | Instruction is an interrupt return |
| opnd_a | input | 64 | Operand A; saved machine state for interrupt return |
| opnd_b | input | 64 | Operand B; saved return address for interrupt return |
| redir_valid | output | 1 | Registered redirect request to fetch |
| redir_addr | output | 64 | Redirect target address, low bits untouched |
| redir_set_msr | output | 1 | Redirect also loads new machine state |
| redir_msr | output | 64 | New machine state for the redirect |
| flush | output | 1 | Registered flush strobe to fetch and decode |
| cf_rd_data | output | 64 | Come-from register read data |

## Verification
The bench applies random mixes of taken and not-taken branches, interrupt returns, bubbles and stalls, with full-width random addresses and operands. Each of these shows whether the redirect and the come-from register react only to accepted taken work. Directed back-to-back taken instructions separate correct squashing from a redirect that repeats. An interrupt return with its branch fields also asserted shows whether the target and state are chosen from the correct operand ports. Targets and instruction addresses with the low two bits set show whether any masking was added.

// File: rtl/br_pkg.sv
// Package: shared types for the execute-stage redirect unit.
// Assumes nothing beyond the SystemVerilog language.
package br_pkg;
    // Source of a resolved redirect
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_RFI    = 2'd2
    } redir_src_e;
endpackage

// File: rtl/redirect_resolve.sv
// Module: redirect_resolve
// Decides, in the cycle an instruction is in execute, whether it produces
// a redirect and selects its target and new machine state.
// Assumes: redirect_pending is the registered redirect of this stage; while
// it is high the instruction in execute is on the wrong path and is squashed.
module redirect_resolve
    import br_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MSR_W  = 64
) (
    input  logic              ex_valid,
    input  logic              stall,
    input  logic              redirect_pending,
    input  logic              br_is_branch,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              ex_is_rfi,
    input  logic [MSR_W-1:0]  opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    output redir_src_e        src,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [MSR_W-1:0]  nxt_msr
);
    logic accept;

    // Instruction is accepted only when valid, not stalled and not squashed
    always_comb accept = ex_valid && !stall && !redirect_pending;

    // Classify the redirect source; interrupt return takes precedence
    always_comb begin
        if (!accept)                       src = SRC_NONE;
        else if (ex_is_rfi)                src = SRC_RFI;
        else if (br_is_branch && br_taken) src = SRC_BRANCH;
        else                               src = SRC_NONE;
    end

    // Target/state mux: return path uses operand B for address, A for state
    always_comb begin
        nxt_addr = (src == SRC_RFI) ? opnd_b : br_target;
        nxt_msr  = opnd_a;
    end
endmodule

// File: rtl/redirect_reg.sv
// Module: redirect_reg
// Registers the redirect so fetch and decode see it one clock after
// resolution. Target low bits are passed through; fetch clears them.
// Assumes: src is SRC_NONE whenever no redirect is to be raised.
module redirect_reg
    import br_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MSR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  redir_src_e        src,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [MSR_W-1:0]  nxt_msr,
    input  logic [MSR_W-1:0]  opnd_a_chk,
    input  logic [ADDR_W-1:0] opnd_b_chk,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              redir_set_msr,
    output logic [MSR_W-1:0]  redir_msr,
    output logic              flush
);
    logic fire;

    // A redirect is raised for any non-empty source
    always_comb fire = (src != SRC_NONE);

    // Control flops: valid, flush and state-load flag, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid   <= 1'b0;
            flush         <= 1'b0;
            redir_set_msr <= 1'b0;
        end else begin
            redir_valid   <= fire;
            flush         <= fire;
            redir_set_msr <= (src == SRC_RFI);
        end
    end

    // Data flops: loaded only when a redirect is raised
    always_ff @(posedge clk) begin
        if (fire) begin
            redir_addr <= nxt_addr;
            redir_msr  <= nxt_msr;
        end
    end

    // R10: a redirect never lasts two cycles in a row
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R10: flush tracks the redirect valid
    p_flush_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush == redir_valid);

    // R5: return redirect takes its target and state from the operand ports
    p_rfi_operands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_RFI) |=> (redir_addr == $past(opnd_b_chk))
                             && (redir_msr == $past(opnd_a_chk)));
endmodule

// File: rtl/cfar_track.sv
// Module: cfar_track
// Come-from register: holds the address of the last taken branch or
// interrupt return, readable as a special-purpose register.
// Assumes: load_en is high only for an accepted redirecting instruction.
module cfar_track #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cf_q
);
    // Capture the instruction address on each redirecting instruction
    always_ff @(posedge clk) begin
        if (!rst_n)       cf_q <= '0;
        else if (load_en) cf_q <= load_addr;
    end

    // R3: a load makes the instruction address visible next cycle
    p_cf_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cf_q == $past(load_addr));

    // R4: without a load the register keeps its value
    p_cf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(cf_q));
endmodule

// File: rtl/branch_redirect_unit.sv
// Module: branch_redirect_unit (top)
// Execute-stage redirect for taken branches and interrupt returns, with a
// registered redirect/flush and a come-from register.
// Assumes: branch condition is already evaluated on br_taken; fetch clears
// the low two bits of the redirect target.
module branch_redirect_unit
    import br_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MSR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    input  logic              stall,
    input  logic [ADDR_W-1:0] ex_nia,
    input  logic              br_is_branch,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              ex_is_rfi,
    input  logic [MSR_W-1:0]  opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              redir_set_msr,
    output logic [MSR_W-1:0]  redir_msr,
    output logic              flush,
    output logic [ADDR_W-1:0] cf_rd_data
);
    redir_src_e        src;
    logic [ADDR_W-1:0] nxt_addr;
    logic [MSR_W-1:0]  nxt_msr;
    logic              cf_load;

    redirect_resolve #(.ADDR_W(ADDR_W), .MSR_W(MSR_W)) u_resolve (
        .ex_valid         (ex_valid),
        .stall            (stall),
        .redirect_pending (redir_valid),
        .br_is_branch     (br_is_branch),
        .br_taken         (br_taken),
        .br_target        (br_target),
        .ex_is_rfi        (ex_is_rfi),
        .opnd_a           (opnd_a),
        .opnd_b           (opnd_b),
        .src              (src),
        .nxt_addr         (nxt_addr),
        .nxt_msr          (nxt_msr)
    );

    redirect_reg #(.ADDR_W(ADDR_W), .MSR_W(MSR_W)) u_rreg (
        .clk           (clk),
        .rst_n         (rst_n),
        .src           (src),
        .nxt_addr      (nxt_addr),
        .nxt_msr       (nxt_msr),
        .opnd_a_chk    (opnd_a),
        .opnd_b_chk    (opnd_b),
        .redir_valid   (redir_valid),
        .redir_addr    (redir_addr),
        .redir_set_msr (redir_set_msr),
        .redir_msr     (redir_msr),
        .flush         (flush)
    );

    // Come-from register loads on every redirecting instruction
    always_comb cf_load = (src != SRC_NONE);

    cfar_track #(.ADDR_W(ADDR_W)) u_cfar (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (cf_load),
        .load_addr (ex_nia),
        .cf_q      (cf_rd_data)
    );

    // R8: a stalled cycle never yields a redirect
    p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !redir_valid);

    // R7: the instruction under a pending redirect cannot redirect again
    p_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> $stable(cf_rd_data));

    // R9: no redirect without a valid instruction
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> !redir_valid);
endmodule

// File: tb/branch_redirect_unit_tb.sv
module branch_redirect_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_valid, stall, br_is_branch, br_taken, ex_is_rfi;
    logic [63:0] ex_nia, br_target, opnd_a, opnd_b;
    logic        redir_valid, redir_set_msr, flush;
    logic [63:0] redir_addr, redir_msr, cf_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // expected model state
    bit          m_pend;
    bit          m_set;
    logic [63:0] m_addr, m_msr, m_cf;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_redirect_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .stall(stall),
        .ex_nia(ex_nia), .br_is_branch(br_is_branch), .br_taken(br_taken),
        .br_target(br_target), .ex_is_rfi(ex_is_rfi), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .redir_set_msr(redir_set_msr), .redir_msr(redir_msr), .flush(flush),
        .cf_rd_data(cf_rd_data)
    );

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // expected redirect decision for the present inputs
    function automatic bit exp_take(bit pend);
        return ex_valid && !stall && !pend && (ex_is_rfi || (br_is_branch && br_taken));
    endfunction

    // tag naming which requirement the present stimulus exercises
    function automatic string tag_of(bit pend);
        if (!ex_valid) return "R9";
        if (stall)     return "R8";
        if (pend)      return "R7";
        if (ex_is_rfi) return "R5";
        if (br_is_branch && br_taken) return "R3";
        return "R4";
    endfunction

    task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // apply current inputs for one clock, advance model, compare outputs
    task automatic step();
        bit take;
        string tg;
        take = exp_take(m_pend);
        tg = tag_of(m_pend);
        if (take) begin
            m_addr = ex_is_rfi ? opnd_b : br_target;
            m_msr  = opnd_a;
            m_set  = ex_is_rfi;
            m_cf   = ex_nia;
        end
        m_pend = take;
        @(posedge clk);
        @(negedge clk);
        check64(tg, "redir_valid", {63'd0, redir_valid}, {63'd0, m_pend});
        check64("R10", "flush", {63'd0, flush}, {63'd0, m_pend});
        check64(tg, "cf_rd_data", cf_rd_data, m_cf);
        if (m_pend) begin
            check64(take && !m_set ? "R2" : "R5", "redir_addr", redir_addr, m_addr);
            check64(m_set ? "R5" : "R2", "redir_set_msr", {63'd0, redir_set_msr}, {63'd0, m_set});
            if (m_set) check64("R5", "redir_msr", redir_msr, m_msr);
        end
    endtask

    task automatic drive(bit v, bit s, bit b, bit t, bit r,
                         logic [63:0] nia, logic [63:0] tgt,
                         logic [63:0] a, logic [63:0] bb);
        ex_valid = v; stall = s; br_is_branch = b; br_taken = t; ex_is_rfi = r;
        ex_nia = nia; br_target = tgt; opnd_a = a; opnd_b = bb;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        drive(1, 0, 1, 1, 0, 64'h10, 64'h20, 64'h0, 64'h0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check64("R1", "redir_valid", {63'd0, redir_valid}, 64'd0);
        check64("R1", "flush", {63'd0, flush}, 64'd0);
        check64("R1", "cf_rd_data", cf_rd_data, 64'd0);
        m_pend = 0; m_set = 0; m_cf = '0; m_addr = '0; m_msr = '0;
        drive(0, 0, 0, 0, 0, '0, '0, '0, '0);
        rst_n = 1'b1;
        step();

        // R2/R3/R6: taken branch with low bits set
        drive(1, 0, 1, 1, 0, 64'h1234_5678_9ABC_DEF3, 64'hFEDC_BA98_7654_3217, '0, '0);
        step();
        // R7: next instruction is squashed even though taken
        drive(1, 0, 1, 1, 0, 64'hAAAA_0000_0000_0004, 64'h5555_0000_0000_0008, '0, '0);
        step();
        // R4: not-taken branch
        drive(1, 0, 1, 0, 0, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0200, '0, '0);
        step();
        // R5/R6: interrupt return with branch fields also set
        drive(1, 0, 1, 1, 1, 64'h0000_0000_0000_0701, 64'hDEAD_BEEF_0000_0000,
              64'h8000_0000_0000_1033, 64'h0000_0000_C000_0002);
        step();
        // R7: interrupt return right after is squashed
        drive(1, 0, 0, 0, 1, 64'h900, '0, 64'h1, 64'h2);
        step();
        // R8: stalled taken branch
        drive(1, 1, 1, 1, 0, 64'h3000, 64'h4000, '0, '0);
        step();
        // R9: invalid interrupt return
        drive(0, 0, 0, 0, 1, 64'h5000, '0, 64'h7, 64'h8);
        step();

        // random mix
        for (int i = 0; i < NRAND; i++) begin
            drive(($urandom % 10) < 8, ($urandom % 5) == 0, $urandom % 2,
                  $urandom % 2, ($urandom % 6) == 0,
                  rnd64(), rnd64(), rnd64(), rnd64());
            step();
        end
        finish_run();
    end
endmodule